// File: doc/BRIEF.md
# Circular Command Queue Consumer

This block walks a circular command queue that software fills in memory. Software programs a queue base address and a runtime log2 size, then moves the producer pointer forward as it writes commands. While the queue is switched on and holds commands, the block fetches one 16-byte entry at a time from memory over a request/acknowledge handshake. It checks the 8-bit opcode of each entry and then either retires the entry by advancing the consumer pointer or stops on it with an error code. The block decodes commands only. It does not execute them.

Each pointer is an index of `log2size` bits with a wrap bit directly above it. Full and empty are derived from these two parts alone. The consumer register also holds a 7-bit error field above the pointer. When that field is non-zero, consumption is frozen. Software restarts the queue by rewriting the consumer register with the field cleared.

The controller has three states:
- **IDLE** waits for work. It moves to FETCH when the queue is enabled, not empty and error-free.
- **FETCH** holds the memory request until acknowledge. On a good opcode it moves back to IDLE. On an illegal opcode or an aborted response it moves to HALT.
- **HALT** waits until the error field reads zero, then returns to IDLE.

Top module: `cmdq_consumer`

## Requirements
- R1: Register map, at `cfg_addr`:
  - 0: control. Bit 0 is the global enable and bit 3 is the queue enable.
  - 1: log2 size, in bits 4:0.
  - 2: base address bits 31:0.
  - 3: base address bits 51:32.
  - 4: producer.
  - 5: consumer. The error field is in bits 30:24 and the pointer in bits 19:0.

  All registers reset to zero and read back through `cfg_rdata`. A producer or consumer write keeps only the low log2size+1 bits.
- R2: `q_empty` is high exactly when the producer and consumer agree in both index and wrap bit.
- R3: `q_full` is high exactly when the indices agree and the wrap bits differ. It is never high together with `q_empty`.
- R4: Retiring an entry changes only the low log2size+1 bits of the consumer register. The error field keeps its value.
- R5: On each retired entry the consumer pointer advances by one. When the index passes 2^log2size−1 it returns to 0 and the wrap bit toggles.
- R6: `mem_addr` equals the base address with bits 5:0 cleared, plus 16 times the masked consumer index. The request stays high until `mem_ack`.
- R7: The opcode is in bits 7:0 of the entry. The legal opcodes are 0x01–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41 and 0x44–0x46. Any other opcode sets the error field to 1 (illegal command) and leaves the consumer on the faulting entry.
- R8: A fetch starts only when control bits 0 and 3 are both set.
- R9: Each error raises `gerr_pulse` for exactly one cycle. Fetching resumes only after software clears the error field.
- R10: The log2 size saturates at 19. A write to it takes effect only while the queue enable bit is clear.
- R11: A response with `mem_rerr` high sets the error field to 2 (abort). The consumer does not move.
- R12: Each retired entry gives a one-cycle `cmd_pop` with its opcode on `cmd_opcode`, one cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req | output | 1 | Entry fetch request |
| mem_addr | output | AW (52) | Byte address of the entry being fetched |
| mem_ack | input | 1 | Fetch response valid |
| mem_rerr | input | 1 | Fetch response aborted |
| mem_rdata | input | 128 | Fetched 16-byte entry |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| cmd_pop | output | 1 | Entry retired this cycle |
| cmd_opcode | output | 8 | Opcode of the last retired entry |
| gerr_pulse | output | 1 | One-cycle error notification |

## Verification
The assertions check these properties on every cycle:
- full and empty are never high together;
- a retire moves the consumer by exactly one step under the wrap mask and leaves the error field alone;
- an error holds the consumer in place and pulses for exactly one cycle;
- a request never starts while the queue is disabled, empty or in error, and it holds until acknowledge;
- the log2 size never exceeds its cap.

Some behaviours appear only in the bench scenarios, which compare the block against a behavioural model:
- the exact entry addresses for an unaligned base;
- the wrap-bit toggle on the register readback;
- the legality decision across varied opcodes;
- the abort code;
- the blocked log2 size write;
- the restart after software clears the error field.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int REG_AW = 3;
    typedef logic [REG_AW-1:0] reg_addr_t;

    localparam reg_addr_t RA_CTRL    = 3'd0;
    localparam reg_addr_t RA_LOG2    = 3'd1;
    localparam reg_addr_t RA_BASE_LO = 3'd2;
    localparam reg_addr_t RA_BASE_HI = 3'd3;
    localparam reg_addr_t RA_PROD    = 3'd4;
    localparam reg_addr_t RA_CONS    = 3'd5;

    localparam int CTRL_GLB_BIT = 0;
    localparam int CTRL_QEN_BIT = 3;

    localparam int ERR_LSB     = 24;
    localparam int ERR_W       = 7;
    localparam int ENTRY_SHIFT = 4;
    localparam int ALIGN_BITS  = 6;
    localparam int CMD_W       = 128;
    localparam int OP_W        = 8;

    localparam logic [ERR_W-1:0] CERR_NONE = 7'd0;
    localparam logic [ERR_W-1:0] CERR_ILL  = 7'd1;
    localparam logic [ERR_W-1:0] CERR_ABT  = 7'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HALT
    } cq_state_e;
endpackage

// File: rtl/cq_op_decode.sv
module cq_op_decode
    import cq_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output logic            legal
);
    always_comb begin
        legal = opcode inside {[8'h01:8'h07], [8'h10:8'h13], 8'h18, 8'h1A,
                               [8'h20:8'h23], 8'h28, 8'h2A, 8'h30,
                               8'h40, 8'h41, [8'h44:8'h46]};
    end
endmodule

// File: rtl/cq_ptr_unit.sv
module cq_ptr_unit
    import cq_pkg::*;
#(
    parameter int PTR_W = 20,
    parameter int LSZ_W = 5,
    parameter int AW    = 52
) (
    input  logic [LSZ_W-1:0]         lsz,
    input  logic [PTR_W-1:0]         prod,
    input  logic [PTR_W-1:0]         cons,
    input  logic [AW-ALIGN_BITS-1:0] base_aligned,
    output logic                     full,
    output logic                     empty,
    output logic [PTR_W-1:0]         wim,
    output logic [PTR_W-1:0]         cons_inc,
    output logic [AW-1:0]            entry_addr
);
    logic [PTR_W-1:0] wrap_bit;
    logic [PTR_W-1:0] idx_mask;
    logic [PTR_W-1:0] diff;
    logic [PTR_W-1:0] idx;

    assign wrap_bit   = PTR_W'(1) << lsz;
    assign idx_mask   = wrap_bit - PTR_W'(1);
    assign wim        = wrap_bit | idx_mask;
    assign diff       = (cons ^ prod) & wim;
    assign empty      = (diff == '0);
    assign full       = (diff == wrap_bit);
    assign cons_inc   = (cons + PTR_W'(1)) & wim;
    assign idx        = cons & idx_mask;
    assign entry_addr = {base_aligned, {ALIGN_BITS{1'b0}}} + (AW'(idx) << ENTRY_SHIFT);
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
    import cq_pkg::*;
#(
    parameter int MAX_LOG2 = 19,
    parameter int AW       = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic             mem_rerr,
    input  logic [CMD_W-1:0] mem_rdata,
    output logic             q_full,
    output logic             q_empty,
    output logic             cmd_pop,
    output logic [OP_W-1:0]  cmd_opcode,
    output logic             gerr_pulse
);
    localparam int PTR_W = MAX_LOG2 + 1;
    localparam int LSZ_W = $clog2(MAX_LOG2 + 1);
    localparam int HI_W  = AW - 32;
    localparam int PAD_W = ERR_LSB - PTR_W;

    cq_state_e          state, state_nx;
    logic               ctrl_glb, ctrl_qen;
    logic [LSZ_W-1:0]   lsz;
    logic [31:0]        base_lo;
    logic [HI_W-1:0]    base_hi;
    logic [PTR_W-1:0]   prod, cons_ptr, wim, cons_inc;
    logic [ERR_W-1:0]   cons_err;
    logic               op_legal, q_on, resp, resp_good, resp_bad;
    logic               unused_cmd_bits;

    assign unused_cmd_bits = ^mem_rdata[CMD_W-1:OP_W];

    cq_ptr_unit #(.PTR_W(PTR_W), .LSZ_W(LSZ_W), .AW(AW)) u_ptr (
        .lsz          (lsz),
        .prod         (prod),
        .cons         (cons_ptr),
        .base_aligned ({base_hi, base_lo[31:ALIGN_BITS]}),
        .full         (q_full),
        .empty        (q_empty),
        .wim          (wim),
        .cons_inc     (cons_inc),
        .entry_addr   (mem_addr)
    );

    cq_op_decode u_dec (
        .opcode (mem_rdata[OP_W-1:0]),
        .legal  (op_legal)
    );

    assign q_on      = ctrl_glb && ctrl_qen;
    assign mem_req   = (state == ST_FETCH);
    assign resp      = mem_req && mem_ack;
    assign resp_good = resp && !mem_rerr && op_legal;
    assign resp_bad  = resp && (mem_rerr || !op_legal);

    // configuration registers and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_glb <= 1'b0;
            ctrl_qen <= 1'b0;
            lsz      <= '0;
            base_lo  <= '0;
            base_hi  <= '0;
            prod     <= '0;
            cons_ptr <= '0;
            cons_err <= CERR_NONE;
        end else begin
            if (cfg_we) begin
                unique case (cfg_addr)
                    RA_CTRL: begin
                        ctrl_glb <= cfg_wdata[CTRL_GLB_BIT];
                        ctrl_qen <= cfg_wdata[CTRL_QEN_BIT];
                    end
                    RA_LOG2: begin
                        if (!ctrl_qen)
                            lsz <= (cfg_wdata > 32'(MAX_LOG2)) ? LSZ_W'(MAX_LOG2)
                                                               : cfg_wdata[LSZ_W-1:0];
                    end
                    RA_BASE_LO: base_lo <= cfg_wdata;
                    RA_BASE_HI: base_hi <= cfg_wdata[HI_W-1:0];
                    RA_PROD:    prod    <= cfg_wdata[PTR_W-1:0] & wim;
                    RA_CONS: begin
                        if (!resp) begin
                            cons_ptr <= cfg_wdata[PTR_W-1:0] & wim;
                            cons_err <= cfg_wdata[ERR_LSB +: ERR_W];
                        end
                    end
                    default: ;
                endcase
            end
            if (resp) begin
                if (mem_rerr)
                    cons_err <= CERR_ABT;
                else if (op_legal)
                    cons_ptr <= cons_inc;
                else
                    cons_err <= CERR_ILL;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (q_on && !q_empty && cons_err == CERR_NONE) state_nx = ST_FETCH;
            ST_FETCH: if (mem_ack) state_nx = (mem_rerr || !op_legal) ? ST_HALT : ST_IDLE;
            ST_HALT:  if (cons_err == CERR_NONE) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pop    <= 1'b0;
            gerr_pulse <= 1'b0;
            cmd_opcode <= '0;
        end else begin
            cmd_pop    <= resp_good;
            gerr_pulse <= resp_bad;
            if (resp_good) cmd_opcode <= mem_rdata[OP_W-1:0];
        end
    end

    // register readback
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            RA_CTRL:    cfg_rdata = 32'({ctrl_qen, 2'b00, ctrl_glb});
            RA_LOG2:    cfg_rdata = 32'(lsz);
            RA_BASE_LO: cfg_rdata = base_lo;
            RA_BASE_HI: cfg_rdata = 32'(base_hi);
            RA_PROD:    cfg_rdata = 32'(prod);
            RA_CONS:    cfg_rdata = {1'b0, cons_err, {PAD_W{1'b0}}, cons_ptr};
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cq_consumer_chk.sv
module cq_consumer_chk #(
    parameter int PTR_W    = 20,
    parameter int LSZ_W    = 5,
    parameter int ERR_W    = 7,
    parameter int MAX_LOG2 = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_ack,
    input logic             q_full,
    input logic             q_empty,
    input logic             cmd_pop,
    input logic             gerr_pulse,
    input logic [PTR_W-1:0] cons_ptr,
    input logic [ERR_W-1:0] cons_err,
    input logic [LSZ_W-1:0] lsz,
    input logic             ctrl_glb,
    input logic             ctrl_qen
);
    logic [PTR_W-1:0] c_wrap, c_wim;
    assign c_wrap = PTR_W'(1) << lsz;
    assign c_wim  = c_wrap | (c_wrap - PTR_W'(1));

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty)); // R3
    AST_POP_KEEPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> cons_err == $past(cons_err)); // R4
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> (((cons_ptr - $past(cons_ptr)) & c_wim) == PTR_W'(1))); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req); // R6
    AST_ERR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        gerr_pulse |-> (cons_err != '0) && (cons_ptr == $past(cons_ptr))); // R7
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(ctrl_glb && ctrl_qen && !q_empty && cons_err == '0)); // R8
    AST_GERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gerr_pulse |=> !gerr_pulse); // R9
    AST_LSZ_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lsz) <= MAX_LOG2); // R10
    AST_POP_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_pop && gerr_pulse)); // R12
endmodule

bind cmdq_consumer cq_consumer_chk #(
    .PTR_W(PTR_W), .LSZ_W(LSZ_W), .ERR_W(cq_pkg::ERR_W), .MAX_LOG2(MAX_LOG2)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .q_full(q_full), .q_empty(q_empty), .cmd_pop(cmd_pop), .gerr_pulse(gerr_pulse),
    .cons_ptr(cons_ptr), .cons_err(cons_err), .lsz(lsz),
    .ctrl_glb(ctrl_glb), .ctrl_qen(ctrl_qen)
);

// File: tb/cmdq_consumer_test.sv
module cmdq_consumer_test;
    localparam int LAT = 2;
    localparam longint BASE_MASK = 64'h000F_FFFF_FFFF_FFC0;

    logic         clk = 1'b0, rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0, cfg_rdata;
    logic         mem_req, mem_ack = 1'b0, mem_rerr = 1'b0;
    logic [51:0]  mem_addr;
    logic [127:0] mem_rdata = '0;
    logic         q_full, q_empty, cmd_pop, gerr_pulse;
    logic [7:0]   cmd_opcode;

    cmdq_consumer uut (.*);

    always #10 clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    // behavioural model state
    int unsigned m_lsz = 0, m_prod = 0, m_cons = 0, m_err = 0;
    bit m_glb = 0, m_qen = 0;
    longint m_base = 0;
    bit exp_pop = 0, exp_gerr = 0, prev_req = 0, prev_ok = 0;
    bit [7:0] exp_op = 0;
    bit [7:0] mem_op [longint];
    bit       mem_abt [longint];
    int wcnt = 0;

    function automatic int unsigned wim();
        return (32'd2 << m_lsz) - 1;
    endfunction
    function automatic bit m_empty();
        return ((m_cons ^ m_prod) & wim()) == 0;
    endfunction
    function automatic bit m_full();
        return ((m_cons ^ m_prod) & wim()) == (32'd1 << m_lsz);
    endfunction
    function automatic longint m_addr(int unsigned idx);
        return (m_base & BASE_MASK) + 16 * longint'(idx & ((32'd1 << m_lsz) - 1));
    endfunction
    function automatic bit legal(bit [7:0] o);
        if (o >= 8'h01 && o <= 8'h07) return 1;
        if (o >= 8'h10 && o <= 8'h13) return 1;
        if (o >= 8'h20 && o <= 8'h23) return 1;
        if (o >= 8'h44 && o <= 8'h46) return 1;
        return (o == 8'h18 || o == 8'h1A || o == 8'h28 || o == 8'h2A ||
                o == 8'h30 || o == 8'h40 || o == 8'h41);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model update on the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lsz = 0; m_prod = 0; m_cons = 0; m_err = 0;
            m_glb = 0; m_qen = 0; m_base = 0; exp_pop = 0; exp_gerr = 0;
        end else begin
            exp_pop = 0; exp_gerr = 0;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: begin m_glb = cfg_wdata[0]; m_qen = cfg_wdata[3]; end
                    3'd1: if (!m_qen) m_lsz = (cfg_wdata > 19) ? 19 : cfg_wdata;
                    3'd2: m_base[31:0] = cfg_wdata;
                    3'd3: m_base[63:32] = cfg_wdata;
                    3'd4: m_prod = cfg_wdata & wim();
                    3'd5: if (!mem_ack) begin
                        m_cons = cfg_wdata & wim();
                        m_err = (cfg_wdata >> 24) & 7'h7F;
                    end
                    default: ;
                endcase
            end
            if (mem_ack) begin
                if (mem_rerr) begin m_err = 2; exp_gerr = 1; end
                else if (legal(mem_rdata[7:0])) begin
                    m_cons = (m_cons + 1) & wim(); exp_pop = 1; exp_op = mem_rdata[7:0];
                end else begin m_err = 1; exp_gerr = 1; end
            end
        end
    end

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0; mem_rerr = 0;
        end else if (rst_n && mem_req) begin
            wcnt++;
            if (wcnt >= LAT) begin
                longint a;
                wcnt = 0;
                a = longint'(mem_addr);
                mem_ack = 1;
                mem_rerr = mem_abt.exists(a);
                mem_rdata = {96'hA5A5_0000_1111_2222_3333_4444, 24'h00C0DE,
                             mem_op.exists(a) ? mem_op[a] : 8'h00};
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 q_empty", q_empty, m_empty());
            chk("R3 q_full", q_full, m_full());
            chk("R12 cmd_pop", cmd_pop, exp_pop);
            if (exp_pop) chk("R12 cmd_opcode", cmd_opcode, exp_op);
            chk("R9 gerr_pulse", gerr_pulse, exp_gerr);
            if (mem_req) chk("R6 mem_addr", longint'(mem_addr), m_addr(m_cons));
            if (mem_req && !prev_req) chk("R8 fetch start allowed", prev_ok, 1);
            prev_req = mem_req;
            prev_ok = m_glb && m_qen && !m_empty() && m_err == 0;
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask
    task automatic rd_chk(string req, logic [2:0] a, longint exp);
        @(negedge clk); cfg_addr = a; #1;
        chk(req, cfg_rdata, exp);
    endtask
    task automatic put(int idx, bit [7:0] op);
        mem_op[(m_base & BASE_MASK) + 16 * idx] = op;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        rd_chk("R1 reset consumer", 3'd5, 0);
        rd_chk("R1 reset producer", 3'd4, 0);
        chk("R2 reset empty", q_empty, 1);
        chk("R3 reset not full", q_full, 0);
        // configuration: 4 entries, unaligned base with junk high bits
        wr(3'd1, 2);
        rd_chk("R10 log2 readback", 3'd1, 2);
        wr(3'd2, 32'h1234_56A5);
        wr(3'd3, 32'hFFF0_0009);
        wr(3'd4, 32'h1F);
        rd_chk("R1 producer masked", 3'd4, 7);
        wr(3'd4, 4);
        chk("R3 full at wrap", q_full, 1);
        put(0, 8'h01); put(1, 8'h46); put(2, 8'h2A); put(3, 8'h10);
        wr(3'd0, 32'h9);
        idle(40);
        rd_chk("R5 wrap bit toggled", 3'd5, 4);
        chk("R2 drained", q_empty, 1);
        // illegal opcode halts
        put(0, 8'h05); put(1, 8'h08); put(2, 8'h30);
        wr(3'd4, 7);
        idle(30);
        rd_chk("R7 illegal halts", 3'd5, (1 << 24) | 5);
        chk("R7 not empty", q_empty, 0);
        idle(20);
        rd_chk("R9 stays halted", 3'd5, (1 << 24) | 5);
        put(1, 8'h45);
        wr(3'd5, 5);
        idle(30);
        rd_chk("R4 resume, error field clear", 3'd5, 7);
        // abort response
        mem_abt[(m_base & BASE_MASK) + 48] = 1;
        put(3, 8'h01);
        wr(3'd4, 0);
        idle(20);
        rd_chk("R11 abort code", 3'd5, (2 << 24) | 7);
        mem_abt.delete();
        wr(3'd5, 7);
        idle(20);
        rd_chk("R5 index wraps to zero", 3'd5, 0);
        // enable gating
        put(0, 8'h20);
        wr(3'd0, 32'h1);
        wr(3'd4, 1);
        idle(20);
        rd_chk("R8 global only", 3'd5, 0);
        wr(3'd0, 32'h8);
        idle(20);
        rd_chk("R8 queue only", 3'd5, 0);
        wr(3'd0, 32'h9);
        idle(20);
        rd_chk("R8 both enables", 3'd5, 1);
        // log2 size write rules
        wr(3'd1, 5);
        rd_chk("R10 blocked while enabled", 3'd1, 2);
        wr(3'd0, 0);
        wr(3'd1, 25);
        rd_chk("R10 saturates", 3'd1, 19);
        idle(5);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule